// File: doc/BRIEF.md
# Stochastic-Delay Excitation Pulse Sequencer

This block times the excitation of an external volatile threshold-switching element, which is used as an entropy source. Each cycle it raises a drive-enable level for a fixed number of reference-clock ticks. The element switches on at a random moment inside that window, and the randomness is taken from that moment alone. After the window it offers a low-amplitude read phase that lets the analog side confirm the element has turned off again. The cycle length, the pulse width and the read-phase placement are tick counts supplied on input buses. A new setting takes effect only at the next cycle boundary. For example, with a 1 MHz tick, a width of 300 and a period of 1000 give a 300 µs pulse followed by 700 µs low, which is a 1 kHz cycle.

The digitised switch-detect input passes through a two-flop synchroniser before any check uses it. When the drive pulse ends, the block emits a one-cycle window-done strobe together with a validity verdict. A window is invalid if the element never switched during the pulse. It is also invalid if the element was still on at the boundary where this pulse began. A run input starts the sequence at the top of a pulse. When run is withdrawn, the sequence halts only after the current cycle has finished.

Top module: `stoch_pulse_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, drive_en, read_en, win_done, win_valid, win_err_noswitch and win_err_norelax are all 0.
- R2: With W = latched width and P = latched period (1 <= W < P), each cycle lasts P ticks, numbered 0 to P-1. drive_en is 1 exactly on ticks 0 to W-1.
- R3: read_en is 1 exactly on ticks t with RS <= t < RS+RL, where RS is the latched read start and RL is the latched read length, both counted from tick 0 of the cycle.
- R4: The four cfg_* buses are sampled only at the boundary that starts a cycle. A change during a cycle has no effect on that cycle's drive_en or read_en.
- R5: When run is sampled high while idle, tick 0 of a cycle follows on the next clock. At the last tick of a cycle, run sampled low ends the sequence and drive_en stays 0 from then on. Run sampled high at that tick starts the next cycle at once.
- R6: sw_det is used only after a two-register synchroniser. A high level first presented on tick W-2 or later of the pulse does not count as a switch for that pulse, while one held from tick W-3 does count.
- R7: win_done is a single-cycle strobe that is high on tick W, the first low tick after each pulse.
- R8: On the win_done cycle, win_err_noswitch is 1 if the synchronised detect was low on every drive tick of that pulse. At all other times it is 0.
- R9: On the win_done cycle, win_err_norelax is 1 if the synchronised detect was high at the boundary that started this pulse. This boundary is the last tick of the previous cycle or the idle tick that began the run. At all other times the flag is 0.
- R10: On the win_done cycle, win_valid is 1 exactly when neither error flag is 1. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start/stop request, acted on only at cycle boundaries |
| cfg_width | input | 16 | Drive pulse length in ticks |
| cfg_period | input | 16 | Full cycle length in ticks |
| cfg_rd_start | input | 16 | Tick offset of the read phase from cycle start |
| cfg_rd_len | input | 16 | Read phase length in ticks |
| sw_det | input | 1 | Asynchronous switch-detect from the comparator |
| drive_en | output | 1 | Excitation pulse enable |
| read_en | output | 1 | Low-amplitude read phase enable |
| win_done | output | 1 | One-cycle strobe at the end of each pulse |
| win_valid | output | 1 | Window entropy usable, qualified by win_done |
| win_err_noswitch | output | 1 | No switch seen during the pulse, qualified by win_done |
| win_err_norelax | output | 1 | Element still on at pulse start, qualified by win_done |

## Verification
The assertions assume that the configuration buses hold a sane setting whenever a boundary samples them. That setting has a width of at least one tick, a width shorter than the period, and a read phase that ends within the period. The stimulus draws the width first, then a larger period, and then a read start and length that fit inside the period, so every load obeys this even when the buses change in mid-cycle. The element model raises detect after a drawn number of pulse ticks, drops it when drive falls, and sometimes holds it past the pulse to provoke the relaxation fault.

// File: rtl/pseq_pkg.sv
// Package: shared widths and the latched configuration record of the
// excitation pulse sequencer. Assumes all tick counts share one width.
package pseq_pkg;
    localparam int TICK_W      = 16;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic [TICK_W-1:0] width;
        logic [TICK_W-1:0] period;
        logic [TICK_W-1:0] rd_start;
        logic [TICK_W-1:0] rd_len;
    } seq_cfg_t;
endpackage

// File: rtl/pseq_sync.sv
// Module: multi-stage synchroniser for one asynchronous level.
// Assumes STAGES >= 2; output lags the input by STAGES clocks.
module pseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // capture the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // shift one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pseq_timebase.sv
// Module: cycle tick counter with boundary-latched configuration.
// Decodes drive and read phases from the tick. Assumes the loaded
// setting has 1 <= width < period and rd_start + rd_len <= period.
module pseq_timebase
    import pseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  seq_cfg_t cfg_in,
    output logic     active,
    output logic     load,
    output logic     pulse_last,
    output logic     drive_en,
    output logic     read_en
);
    localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

    logic              active_q;
    logic [TICK_W-1:0] tick_q;
    seq_cfg_t          cfg_q;
    logic              last_tick;
    logic [TICK_W:0]   rd_end;

    // boundary decode: last tick of a cycle, and whether a new cycle loads
    always_comb begin
        last_tick  = active_q && (tick_q == cfg_q.period - ONE);
        load       = run && (!active_q || last_tick);
        pulse_last = active_q && (tick_q == cfg_q.width - ONE);
    end

    // tick counter, run state and configuration shadow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            tick_q   <= '0;
            cfg_q    <= '0;
        end else if (load) begin
            cfg_q    <= cfg_in;
            tick_q   <= '0;
            active_q <= 1'b1;
        end else if (last_tick) begin
            active_q <= 1'b0;
            tick_q   <= '0;
        end else if (active_q) begin
            tick_q   <= tick_q + ONE;
        end
    end

    // phase decode for the drive pulse and the read window
    always_comb begin
        rd_end   = {1'b0, cfg_q.rd_start} + {1'b0, cfg_q.rd_len};
        drive_en = active_q && (tick_q < cfg_q.width);
        read_en  = active_q && (tick_q >= cfg_q.rd_start) && ({1'b0, tick_q} < rd_end);
    end

    assign active = active_q;

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (tick_q < cfg_q.period)); // R2
    AST_DRIVE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> (tick_q == '0)); // R2
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && tick_q != '0) |-> $stable(cfg_q)); // R4
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> ($past(tick_q) == $past(cfg_q.period) - ONE)); // R5
endmodule

// File: rtl/pseq_monitor.sv
// Module: per-window validity monitor. Tracks whether the synchronised
// detect rose during the pulse and whether it was low at the boundary
// that began the pulse; reports both on the strobe after the pulse.
// Assumes sw_s is already synchronised to clk.
module pseq_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_s,
    input  logic load,
    input  logic pulse_last,
    input  logic drive_en,
    output logic win_done,
    output logic win_valid,
    output logic win_err_noswitch,
    output logic win_err_norelax
);
    logic seen_q;
    logic relax_bad_q;
    logic no_switch;

    // a switch counts if seen earlier or present on the final drive tick
    always_comb no_switch = !(seen_q || sw_s);

    // window bookkeeping: switch seen, relaxation fault at pulse start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            relax_bad_q <= 1'b0;
        end else if (load) begin
            seen_q      <= 1'b0;
            relax_bad_q <= sw_s;
        end else if (drive_en && sw_s) begin
            seen_q      <= 1'b1;
        end
    end

    // end-of-pulse report registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_done         <= 1'b0;
            win_valid        <= 1'b0;
            win_err_noswitch <= 1'b0;
            win_err_norelax  <= 1'b0;
        end else begin
            win_done         <= pulse_last;
            win_err_noswitch <= pulse_last && no_switch;
            win_err_norelax  <= pulse_last && relax_bad_q;
            win_valid        <= pulse_last && !no_switch && !relax_bad_q;
        end
    end

    AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $fell(drive_en)); // R7
    AST_NOSWITCH_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        win_err_noswitch |-> win_done); // R8
    AST_NORELAX_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        win_err_norelax |-> win_done); // R9
    AST_VALID_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (win_valid != (win_err_noswitch || win_err_norelax))); // R10
endmodule

// File: rtl/stoch_pulse_seq.sv
// Module: top of the excitation pulse sequencer. Joins the detect
// synchroniser, the cycle timebase and the window monitor. Assumes the
// cfg buses hold a sane setting whenever a cycle boundary samples them.
module stoch_pulse_seq
    import pseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TICK_W-1:0] cfg_width,
    input  logic [TICK_W-1:0] cfg_period,
    input  logic [TICK_W-1:0] cfg_rd_start,
    input  logic [TICK_W-1:0] cfg_rd_len,
    input  logic              sw_det,
    output logic              drive_en,
    output logic              read_en,
    output logic              win_done,
    output logic              win_valid,
    output logic              win_err_noswitch,
    output logic              win_err_norelax
);
    seq_cfg_t cfg_bus;
    logic     sw_s;
    logic     active;
    logic     load;
    logic     pulse_last;

    // bundle the configuration buses into one record
    always_comb begin
        cfg_bus.width    = cfg_width;
        cfg_bus.period   = cfg_period;
        cfg_bus.rd_start = cfg_rd_start;
        cfg_bus.rd_len   = cfg_rd_len;
    end

    pseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sw_det),
        .q_sync  (sw_s)
    );

    pseq_timebase u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cfg_in     (cfg_bus),
        .active     (active),
        .load       (load),
        .pulse_last (pulse_last),
        .drive_en   (drive_en),
        .read_en    (read_en)
    );

    pseq_monitor u_monitor (
        .clk              (clk),
        .rst_n            (rst_n),
        .sw_s             (sw_s),
        .load             (load),
        .pulse_last       (pulse_last),
        .drive_en         (drive_en),
        .win_done         (win_done),
        .win_valid        (win_valid),
        .win_err_noswitch (win_err_noswitch),
        .win_err_norelax  (win_err_norelax)
    );

    AST_DRIVE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> active); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done); // R7
endmodule

// File: tb/stoch_pulse_seq_bench.sv
// Bench: cycle-level expectation model built from the requirements,
// random configurations and element delays plus directed corners.
module stoch_pulse_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] cfg_width = 16'd4;
    logic [15:0] cfg_period = 16'd12;
    logic [15:0] cfg_rd_start = 16'd5;
    logic [15:0] cfg_rd_len = 16'd3;
    logic        sw_det = 1'b0;
    logic        drive_en, read_en, win_done, win_valid, win_err_noswitch, win_err_norelax;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    // expectation model state
    int m_act = 0, m_tick = 0, m_w = 0, m_p = 0, m_rs = 0, m_rl = 0;
    int m_s1 = 0, m_s2 = 0, m_seen = 0, m_rb = 0;
    int e_done = 0, e_valid = 0, e_ns = 0, e_nr = 0;

    // element model controls
    int force_d = -1;
    int hold_mode = 1;
    int prev_drv = 0, dcnt = 0, dly = 0, hold_cnt = 0;
    int meas_w = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stoch_pulse_seq u_stoch_pulse_seq (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cfg_width(cfg_width), .cfg_period(cfg_period),
        .cfg_rd_start(cfg_rd_start), .cfg_rd_len(cfg_rd_len),
        .sw_det(sw_det), .drive_en(drive_en), .read_en(read_en),
        .win_done(win_done), .win_valid(win_valid),
        .win_err_noswitch(win_err_noswitch), .win_err_norelax(win_err_norelax)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
        end
    endtask

    function automatic int exp_drive();
        return (m_act != 0 && m_tick < m_w) ? 1 : 0;
    endfunction

    function automatic int exp_read();
        return (m_act != 0 && m_tick >= m_rs && m_tick < m_rs + m_rl) ? 1 : 0;
    endfunction

    // expectation model advance, one clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_tick = 0; m_w = 0; m_p = 0; m_rs = 0; m_rl = 0;
            m_s1 = 0; m_s2 = 0; m_seen = 0; m_rb = 0;
            e_done = 0; e_valid = 0; e_ns = 0; e_nr = 0;
        end else begin
            int drv, plast, last, ld;
            drv   = exp_drive();
            plast = (m_act != 0 && m_tick == m_w - 1) ? 1 : 0;
            last  = (m_act != 0 && m_tick == m_p - 1) ? 1 : 0;
            ld    = (run && (m_act == 0 || last != 0)) ? 1 : 0;
            e_done  = plast;
            e_ns    = (plast != 0 && m_seen == 0 && m_s2 == 0) ? 1 : 0;
            e_nr    = (plast != 0 && m_rb != 0) ? 1 : 0;
            e_valid = (plast != 0 && e_ns == 0 && e_nr == 0) ? 1 : 0;
            if (ld != 0) begin
                m_seen = 0; m_rb = m_s2;
            end else if (drv != 0 && m_s2 != 0) begin
                m_seen = 1;
            end
            if (ld != 0) begin
                m_w = int'(cfg_width); m_p = int'(cfg_period);
                m_rs = int'(cfg_rd_start); m_rl = int'(cfg_rd_len);
                m_tick = 0; m_act = 1;
            end else if (last != 0) begin
                m_act = 0; m_tick = 0;
            end else if (m_act != 0) begin
                m_tick++;
            end
            m_s2 = m_s1;
            m_s1 = int'(sw_det);
        end
    end

    // compare outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 R5 drive_en", int'(drive_en), exp_drive());
            check("R3 read_en", int'(read_en), exp_read());
            check("R7 win_done", int'(win_done), e_done);
            check("R8 R6 win_err_noswitch", int'(win_err_noswitch), e_ns);
            check("R9 win_err_norelax", int'(win_err_norelax), e_nr);
            check("R10 win_valid", int'(win_valid), e_valid);
            if (drive_en) meas_w++;
            if (win_done) begin
                check("R4 latched pulse width", meas_w, m_w);
                meas_w = 0;
            end
        end
    end

    // element model: switches after a drawn delay, drops when drive ends
    always @(negedge clk) begin
        if (drive_en) begin
            if (prev_drv == 0) begin
                dcnt = 0;
                if (force_d >= 0)                dly = force_d;
                else if ($urandom % 8 == 0)      dly = m_w + int'($urandom % 3);
                else                             dly = int'($urandom % m_w);
            end
            sw_det = (dcnt >= dly);
            dcnt++;
        end else begin
            if (prev_drv != 0 && hold_mode != 0 && $urandom % 6 == 0)
                hold_cnt = 1 + int'($urandom % m_p);
            if (hold_cnt > 0) begin
                sw_det = 1'b1; hold_cnt--;
            end else begin
                sw_det = 1'b0;
            end
        end
        prev_drv = int'(drive_en);
    end

    task automatic wait_done();
        do @(negedge clk); while (!win_done);
    endtask

    task automatic set_cfg(input int w, input int p, input int rs, input int rl);
        cfg_width = 16'(w); cfg_period = 16'(p);
        cfg_rd_start = 16'(rs); cfg_rd_len = 16'(rl);
    endtask

    task automatic random_cfg();
        int w, p, rs, rl;
        w  = 2 + int'($urandom % 8);
        p  = w + 4 + int'($urandom % 20);
        rs = w + int'($urandom % (p - w));
        rl = int'($urandom % (p - rs + 1));
        set_cfg(w, p, rs, rl);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 drive_en", int'(drive_en), 0);
        check("R1 read_en", int'(read_en), 0);
        check("R1 win_done", int'(win_done), 0);
        check("R1 win_valid", int'(win_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle drive_en", int'(drive_en), 0);
        check("R1 first cycle errors", int'(win_err_noswitch) + int'(win_err_norelax), 0);

        // R6: detect presented too late is not counted
        hold_mode = 0;
        set_cfg(6, 20, 8, 4);
        force_d = 4;
        run = 1'b1;
        wait_done();
        check("R6 late detect gives no-switch", int'(win_err_noswitch), 1);
        force_d = 3;
        wait_done();
        check("R6 detect from W-3 counts", int'(win_err_noswitch), 0);
        check("R10 clean window valid", int'(win_valid), 1);

        // R9: element held on across the boundary
        force_d = 0;
        hold_cnt = 0;
        wait_done();
        hold_cnt = 40;
        wait_done();
        check("R9 held detect flags next window", int'(win_err_norelax), 1);
        check("R10 flagged window invalid", int'(win_valid), 0);
        force_d = -1;
        hold_mode = 1;

        // R4: mid-cycle change only affects later cycles
        @(negedge clk);
        set_cfg(3, 15, 4, 6);
        wait_done();
        wait_done();

        // R5: stop and restart, plus random configurations
        for (int s = 0; s < 40; s++) begin
            random_cfg();
            repeat (5 + int'($urandom % 80)) @(negedge clk);
            if ($urandom % 4 == 0) begin
                run = 1'b0;
                repeat (60 + int'($urandom % 20)) @(negedge clk);
                check("R5 halted after stop", int'(drive_en), 0);
                run = 1'b1;
            end
        end
        run = 1'b0;
        repeat (80) @(negedge clk);
        check("R5 idle at end", int'(drive_en), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired: actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule